// File: doc/BRIEF.md
# Partitioned Flash Operation and Suspend Controller

This block is the command-side state keeper for a NOR-style flash array that is split into equal partitions of 4 Mbit (256 Kword) each. It takes one request per cycle (read, program, erase, suspend or resume), each carrying a word address. It decides whether to grant or reject it. It also tracks at most one erase and one program, each as idle, running or held (suspended). The array, the supply handling and the cell physics lie outside the block; an external timer model pulses `op_done` when the running operation finishes.

Reads to a partition with no running operation go ahead while a program or erase runs elsewhere. A running erase can be held so that a program or read can use any other block. That nested program can itself be held so that a read can go through. Resumes unwind in last-in-first-out order. Responses are registered and appear one cycle after the request. The slot state is visible on the outputs as a busy vector, the running partition, the suspend depth and a status word.

Top module: `fop_ctrl`

## Requirements
- R1: After reset no operation is tracked, no response is raised, `susp_depth` is 0, `part_busy` is 0 and `status` equals 8'h01. A reset part-way through a suspended erase leaves nothing held.
- R2: The partition of an address is its top log2(NUM_PART) bits. `part_busy` has exactly the bit of the running operation's partition set and is zero when nothing runs. `active_part` and `active_valid` report the same thing.
- R3: A read to a partition with no running operation is granted with `rsp_rd_status` = 0 (array data), even while another partition programs or erases.
- R4: A read to the partition whose program or erase is running is granted with `rsp_rd_status` = 1 (status returned instead of data).
- R5: A program request is rejected without error while any program or erase is running or a program is held.
- R6: Suspend of a running erase is granted and holds it (depth 1). A read or a program to any block other than the held erase's block is then granted.
- R7: While an erase is held, a read or program whose address falls in the held erase's block is rejected with `rsp_err` = 1. Blocks are 32 Kword (low 15 address bits). The one exception is the lowest 32 Kword of the address space, which holds eight 4 Kword blocks (low 12 bits).
- R8: Suspend of a running program is granted and holds it. With an erase also held the depth becomes 2, and reads to unblocked locations are still granted.
- R9: Resume restarts the held program first. Resume of a held erase is rejected while a program is running or held, and is granted once the program has completed. Resume with nothing held is rejected without error.
- R10: An erase request is granted only when no erase is running or held and no program exists; otherwise it is rejected without error.
- R11: Suspend with no running operation is rejected with `rsp_err` = 1 and changes no state.
- R12: An `op_done` pulse in the same cycle as a request completes the running operation first. The request is then judged against the state left after completion.
- R13: Every request with `req_valid` = 1 gets exactly one of `rsp_grant`/`rsp_reject` in the next cycle. Op codes: 0 read, 1 program, 2 erase, 3 suspend, 4 resume. Other codes are rejected without error. `status` bits: 0 ready (nothing running), 1 erase held, 2 program held, 3 equal to `rsp_err`, the rest zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request code (see R13) |
| req_addr | input | ADDR_W (21) | Word address of the request |
| op_done | input | 1 | Running program or erase has finished |
| rsp_grant | output | 1 | Previous request granted |
| rsp_reject | output | 1 | Previous request rejected |
| rsp_err | output | 1 | Rejection was a rule violation |
| rsp_rd_status | output | 1 | Granted read returns status, not data |
| part_busy | output | NUM_PART (8) | One bit per partition with a running operation |
| active_valid | output | 1 | A program or erase is running |
| active_part | output | PART_W (3) | Partition of the running operation |
| susp_depth | output | 2 | Number of held operations (0 to 2) |
| status | output | 8 | Status word (see R13) |

## Verification
The completion pulse and a new request can land on the same clock edge. The block resolves this by retiring the running operation before it judges the request. The stimulus table raises `op_done` together with a resume (the held erase must restart at once), with a suspend (the erase that just finished leaves nothing to hold, so an error is expected), and with a new erase (accepted because the previous one has just ended). The grant, error, depth and running partition in the following cycle show which order was applied.

// File: rtl/fop_pkg.sv
package fop_pkg;

   // request codes carried on req_op
   typedef enum logic [2:0] {
      OP_READ   = 3'd0,
      OP_PROG   = 3'd1,
      OP_ERASE  = 3'd2,
      OP_SUSP   = 3'd3,
      OP_RESUME = 3'd4
   } fop_op_e;

   // life cycle of one tracked program or erase
   typedef enum logic [1:0] {
      SL_IDLE = 2'd0,
      SL_RUN  = 2'd1,
      SL_HELD = 2'd2
   } slot_e;

   localparam int STAT_W     = 8;
   localparam int ST_READY   = 0;
   localparam int ST_E_HELD  = 1;
   localparam int ST_P_HELD  = 2;
   localparam int ST_ERR     = 3;

endpackage

// File: rtl/fop_blkmap.sv
// Maps a word address to an erase-block key: the address above the small
// block offset, with the low part cleared for ordinary (large) blocks.
module fop_blkmap #(
   parameter  int NUM_PART     = 8,
   parameter  int PART_OFS_W   = 18,
   parameter  int MAIN_OFS_W   = 15,
   parameter  int PARM_OFS_W   = 12,
   parameter  bit PARAM_AT_TOP = 1'b0,
   localparam int PART_W       = $clog2(NUM_PART),
   localparam int ADDR_W       = PART_OFS_W + PART_W,
   localparam int KEY_W        = ADDR_W - PARM_OFS_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [KEY_W-1:0]  key
);
   localparam int SUB_W = MAIN_OFS_W - PARM_OFS_W;

   logic in_small;

   generate
      if (PARAM_AT_TOP) begin : g_small_top
         assign in_small = &addr[ADDR_W-1:MAIN_OFS_W];
      end else begin : g_small_bottom
         assign in_small = ~|addr[ADDR_W-1:MAIN_OFS_W];
      end
   endgenerate

   always_comb begin
      key = addr[ADDR_W-1:PARM_OFS_W];
      if (!in_small) key[SUB_W-1:0] = '0;
   end

endmodule

// File: rtl/fop_slot.sv
// One tracked operation: state plus the block key it works on.
module fop_slot import fop_pkg::*; #(
   parameter int KEY_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             start,
   input  logic             hold,
   input  logic             resume,
   input  logic [KEY_W-1:0] new_key,
   output slot_e            state,
   output logic [KEY_W-1:0] key
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SL_IDLE;
         key   <= '0;
      end else begin
         if (clr) state <= SL_IDLE;
         if (start) begin
            state <= SL_RUN;
            key   <= new_key;
         end else if (hold) begin
            state <= SL_HELD;
         end else if (resume) begin
            state <= SL_RUN;
         end
      end
   end

   // R6
   hold_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> (state == SL_RUN && !clr));

   // R9
   resume_from_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resume |-> (state == SL_HELD));

   // R5
   start_from_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (state == SL_IDLE || clr));

endmodule

// File: rtl/fop_judge.sv
// Combinational request arbitration against the post-completion slot state.
module fop_judge import fop_pkg::*; #(
   parameter int PART_W = 3,
   parameter int KEY_W  = 9
) (
   input  logic             valid,
   input  logic [2:0]       op,
   input  logic [KEY_W-1:0] key,
   input  slot_e            p_st,
   input  slot_e            e_st,
   input  logic [KEY_W-1:0] p_key,
   input  logic [KEY_W-1:0] e_key,
   output logic             grant,
   output logic             reject,
   output logic             err,
   output logic             rd_stat,
   output logic             p_start,
   output logic             p_hold,
   output logic             p_resume,
   output logic             e_start,
   output logic             e_hold,
   output logic             e_resume
);
   logic              running;
   logic              hit_held;
   logic [PART_W-1:0] run_part;
   logic [PART_W-1:0] req_part;

   assign running  = (p_st == SL_RUN) || (e_st == SL_RUN);
   assign run_part = (p_st == SL_RUN) ? p_key[KEY_W-1 -: PART_W] : e_key[KEY_W-1 -: PART_W];
   assign req_part = key[KEY_W-1 -: PART_W];
   assign hit_held = (e_st == SL_HELD) && (key == e_key);

   always_comb begin
      grant    = 1'b0;
      reject   = 1'b0;
      err      = 1'b0;
      rd_stat  = 1'b0;
      p_start  = 1'b0;
      p_hold   = 1'b0;
      p_resume = 1'b0;
      e_start  = 1'b0;
      e_hold   = 1'b0;
      e_resume = 1'b0;
      if (valid) begin
         case (op)
            OP_READ: begin
               if (hit_held) begin
                  reject = 1'b1;
                  err    = 1'b1;
               end else begin
                  grant   = 1'b1;
                  rd_stat = running && (req_part == run_part);
               end
            end
            OP_PROG: begin
               if (hit_held) begin
                  reject = 1'b1;
                  err    = 1'b1;
               end else if (running || p_st != SL_IDLE) begin
                  reject = 1'b1;
               end else begin
                  grant   = 1'b1;
                  p_start = 1'b1;
               end
            end
            OP_ERASE: begin
               if (e_st != SL_IDLE || p_st != SL_IDLE) begin
                  reject = 1'b1;
               end else begin
                  grant   = 1'b1;
                  e_start = 1'b1;
               end
            end
            OP_SUSP: begin
               if (p_st == SL_RUN) begin
                  grant  = 1'b1;
                  p_hold = 1'b1;
               end else if (e_st == SL_RUN) begin
                  grant  = 1'b1;
                  e_hold = 1'b1;
               end else begin
                  reject = 1'b1;
                  err    = 1'b1;
               end
            end
            OP_RESUME: begin
               if (p_st == SL_HELD) begin
                  grant    = 1'b1;
                  p_resume = 1'b1;
               end else if (e_st == SL_HELD && p_st == SL_IDLE) begin
                  grant    = 1'b1;
                  e_resume = 1'b1;
               end else begin
                  reject = 1'b1;
               end
            end
            default: reject = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/fop_ctrl.sv
module fop_ctrl import fop_pkg::*; #(
   parameter  int NUM_PART     = 8,
   parameter  int PART_OFS_W   = 18,
   parameter  int MAIN_OFS_W   = 15,
   parameter  int PARM_OFS_W   = 12,
   parameter  bit PARAM_AT_TOP = 1'b0,
   localparam int PART_W       = $clog2(NUM_PART),
   localparam int ADDR_W       = PART_OFS_W + PART_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [2:0]          req_op,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                op_done,
   output logic                rsp_grant,
   output logic                rsp_reject,
   output logic                rsp_err,
   output logic                rsp_rd_status,
   output logic [NUM_PART-1:0] part_busy,
   output logic                active_valid,
   output logic [PART_W-1:0]   active_part,
   output logic [1:0]          susp_depth,
   output logic [STAT_W-1:0]   status
);
   localparam int KEY_W = ADDR_W - PARM_OFS_W;

   generate
      if (NUM_PART < 2 || (1 << PART_W) != NUM_PART) begin : g_bad_parts
         $error("NUM_PART must be a power of two of at least 2");
      end
      if (!(PARM_OFS_W < MAIN_OFS_W && MAIN_OFS_W < PART_OFS_W)) begin : g_bad_geom
         $error("block offsets must nest: small < large < partition");
      end
   endgenerate

   logic [KEY_W-1:0] req_key, prg_key, ers_key;
   slot_e            prg_st, ers_st, eff_p, eff_e;
   logic             p_clr, e_clr;
   logic             j_grant, j_reject, j_err, j_rd;
   logic             p_start, p_hold, p_resume, e_start, e_hold, e_resume;

   fop_blkmap #(
      .NUM_PART    (NUM_PART),
      .PART_OFS_W  (PART_OFS_W),
      .MAIN_OFS_W  (MAIN_OFS_W),
      .PARM_OFS_W  (PARM_OFS_W),
      .PARAM_AT_TOP(PARAM_AT_TOP)
   ) u_map (
      .addr(req_addr),
      .key (req_key)
   );

   // completion retires the running slot before the request is judged
   assign p_clr = op_done && (prg_st == SL_RUN);
   assign e_clr = op_done && (prg_st != SL_RUN) && (ers_st == SL_RUN);
   assign eff_p = p_clr ? SL_IDLE : prg_st;
   assign eff_e = e_clr ? SL_IDLE : ers_st;

   fop_judge #(.PART_W(PART_W), .KEY_W(KEY_W)) u_judge (
      .valid   (req_valid),
      .op      (req_op),
      .key     (req_key),
      .p_st    (eff_p),
      .e_st    (eff_e),
      .p_key   (prg_key),
      .e_key   (ers_key),
      .grant   (j_grant),
      .reject  (j_reject),
      .err     (j_err),
      .rd_stat (j_rd),
      .p_start (p_start),
      .p_hold  (p_hold),
      .p_resume(p_resume),
      .e_start (e_start),
      .e_hold  (e_hold),
      .e_resume(e_resume)
   );

   fop_slot #(.KEY_W(KEY_W)) u_prog (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (p_clr),
      .start  (p_start),
      .hold   (p_hold),
      .resume (p_resume),
      .new_key(req_key),
      .state  (prg_st),
      .key    (prg_key)
   );

   fop_slot #(.KEY_W(KEY_W)) u_erase (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (e_clr),
      .start  (e_start),
      .hold   (e_hold),
      .resume (e_resume),
      .new_key(req_key),
      .state  (ers_st),
      .key    (ers_key)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_grant     <= 1'b0;
         rsp_reject    <= 1'b0;
         rsp_err       <= 1'b0;
         rsp_rd_status <= 1'b0;
      end else begin
         rsp_grant     <= j_grant;
         rsp_reject    <= j_reject;
         rsp_err       <= j_err;
         rsp_rd_status <= j_rd;
      end
   end

   assign active_valid = (prg_st == SL_RUN) || (ers_st == SL_RUN);
   assign active_part  = (prg_st == SL_RUN) ? prg_key[KEY_W-1 -: PART_W]
                                            : ers_key[KEY_W-1 -: PART_W];
   assign susp_depth   = {1'b0, prg_st == SL_HELD} + {1'b0, ers_st == SL_HELD};

   generate
      for (genvar i = 0; i < NUM_PART; i++) begin : g_busy
         assign part_busy[i] = active_valid && (active_part == PART_W'(i));
      end
   endgenerate

   always_comb begin
      status            = '0;
      status[ST_READY]  = !active_valid;
      status[ST_E_HELD] = (ers_st == SL_HELD);
      status[ST_P_HELD] = (prg_st == SL_HELD);
      status[ST_ERR]    = rsp_err;
   end

   // R13
   answer_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_grant ^ rsp_reject));

   // R13
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(rsp_grant || rsp_reject));

   // R5
   single_runner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(prg_st == SL_RUN && ers_st == SL_RUN));

   // R2
   busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(part_busy));

   // R7
   err_is_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_reject);

   // R7
   nested_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prg_st != SL_IDLE && ers_st == SL_HELD) |-> (prg_key != ers_key));

   // R11
   susp_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_SUSP && !op_done && prg_st != SL_RUN && ers_st != SL_RUN)
      |=> (rsp_err && $stable(prg_st) && $stable(ers_st)));

   // R9
   lifo_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ers_st == SL_RUN && $past(ers_st) == SL_HELD) |-> (prg_st == SL_IDLE));

   // R10
   erase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_grant && $past(req_op) == OP_ERASE) |-> ($past(ers_st) == SL_IDLE || $past(op_done)));

endmodule

// File: tb/fop_ctrl_test.sv
module fop_ctrl_test;
   localparam int CLK_NS = 10;
   localparam int AW     = 21;
   localparam int NROW   = 41;

   typedef struct packed {
      logic          dn;
      logic          vl;
      logic [2:0]    op;
      logic [AW-1:0] ad;
      logic [3:0]    gres;   // {grant, reject, err, rd_status}
      logic [1:0]    dp;
      logic          av;
      logic [2:0]    ap;
      logic [7:0]    rq;
   } row_t;

   function automatic row_t mk(int dn, int vl, int op, int ad, int gres,
                               int dp, int av, int ap, int rq);
      row_t r;
      r.dn   = 1'(dn);
      r.vl   = 1'(vl);
      r.op   = 3'(op);
      r.ad   = AW'(ad);
      r.gres = 4'(gres);
      r.dp   = 2'(dp);
      r.av   = 1'(av);
      r.ap   = 3'(ap);
      r.rq   = 8'(rq);
      return r;
   endfunction

   // op codes: 0 read, 1 program, 2 erase, 3 suspend, 4 resume
   // gres: 8 grant, 9 grant+status, 4 reject, 6 reject+err, 0 no response
   localparam row_t TBL [NROW] = '{
      mk(0,1,2,'h080000,'h8,0,1,2,10), // R10 erase part2 accepted
      mk(0,1,0,'h0C0000,'h8,0,1,2, 3), // R3 read other partition: data
      mk(0,1,0,'h088000,'h9,0,1,2, 4), // R4 read busy partition: status
      mk(0,1,1,'h0C0000,'h4,0,1,2, 5), // R5 program while erase runs
      mk(0,1,2,'h100000,'h4,0,1,2,10), // R10 second erase
      mk(0,1,3,'h000000,'h8,1,0,0, 6), // R6 hold erase
      mk(0,1,0,'h080010,'h6,1,0,0, 7), // R7 read held block
      mk(0,1,1,'h080020,'h6,1,0,0, 7), // R7 program held block
      mk(0,1,0,'h088000,'h8,1,0,0, 6), // R6 read same partition, other block
      mk(0,1,2,'h100000,'h4,1,0,0,10), // R10 erase while one held
      mk(0,1,1,'h088000,'h8,1,1,2, 6), // R6 nested program
      mk(0,1,4,'h000000,'h4,1,1,2, 9), // R9 erase resume blocked by program
      mk(0,1,0,'h088004,'h9,1,1,2, 4), // R4 read programming partition
      mk(0,1,3,'h000000,'h8,2,0,0, 8), // R8 hold program, depth 2
      mk(0,1,0,'h140000,'h8,2,0,0, 8), // R8 read at depth 2
      mk(0,1,4,'h000000,'h8,1,1,2, 9), // R9 program resumes first
      mk(1,0,0,'h000000,'h0,1,0,0, 9), // R9 program completes
      mk(0,1,4,'h000000,'h8,0,1,2, 9), // R9 erase resumes
      mk(1,0,0,'h000000,'h0,0,0,0, 2), // R2 erase completes, idle
      mk(0,1,3,'h000000,'h6,0,0,0,11), // R11 suspend with nothing running
      mk(0,1,4,'h000000,'h4,0,0,0, 9), // R9 resume with nothing held
      mk(0,1,2,'h001000,'h8,0,1,0, 7), // R7 erase small block 1
      mk(0,1,3,'h000000,'h8,1,0,0, 6), // R6 hold it
      mk(0,1,1,'h002000,'h8,1,1,0, 7), // R7 neighbouring small block allowed
      mk(1,0,0,'h000000,'h0,1,0,0, 9), // R9 program completes
      mk(0,1,1,'h001FFF,'h6,1,0,0, 7), // R7 top of held small block
      mk(0,1,1,'h000FFF,'h8,1,1,0, 7), // R7 small block 0 allowed
      mk(1,1,4,'h000000,'h8,0,1,0,12), // R12 done + resume: erase restarts
      mk(1,1,3,'h000000,'h6,0,0,0,12), // R12 done + suspend: nothing left
      mk(0,1,2,'h1C0000,'h8,0,1,7, 2), // R2 last partition
      mk(1,1,2,'h040000,'h8,0,1,1,12), // R12 done + new erase accepted
      mk(1,0,0,'h000000,'h0,0,0,0, 2), // R2 idle again
      mk(0,1,2,'h0C8000,'h8,0,1,3,10), // R10 erase large block 1 of part3
      mk(0,1,3,'h000000,'h8,1,0,0, 6), // R6 hold it
      mk(0,1,1,'h0CFFFF,'h6,1,0,0, 7), // R7 last word of held large block
      mk(0,1,1,'h0D0000,'h8,1,1,3, 7), // R7 next large block allowed
      mk(1,0,0,'h000000,'h0,1,0,0, 9), // R9 program completes
      mk(0,1,0,'h0C8000,'h6,1,0,0, 7), // R7 read held block
      mk(0,1,4,'h000000,'h8,0,1,3, 9), // R9 erase resumes
      mk(1,0,0,'h000000,'h0,0,0,0, 2), // R2 idle
      mk(0,1,7,'h000000,'h4,0,0,0,13)  // R13 unknown code rejected
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic [2:0]    req_op;
   logic [AW-1:0] req_addr;
   logic          op_done;
   logic          rsp_grant, rsp_reject, rsp_err, rsp_rd_status;
   logic [7:0]    part_busy;
   logic          active_valid;
   logic [2:0]    active_part;
   logic [1:0]    susp_depth;
   logic [7:0]    status;

   int checks = 0;
   int errors = 0;

   always #(CLK_NS/2) clk = ~clk;

   fop_ctrl uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_op       (req_op),
      .req_addr     (req_addr),
      .op_done      (op_done),
      .rsp_grant    (rsp_grant),
      .rsp_reject   (rsp_reject),
      .rsp_err      (rsp_err),
      .rsp_rd_status(rsp_rd_status),
      .part_busy    (part_busy),
      .active_valid (active_valid),
      .active_part  (active_part),
      .susp_depth   (susp_depth),
      .status       (status)
   );

   task automatic chk(int rq, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic expect_all(int rq, logic [3:0] gres, logic [1:0] dp, logic av, logic [2:0] ap);
      logic [7:0] eb;
      logic [7:0] es;
      eb = av ? (8'd1 << ap) : 8'd0;
      es = {4'b0, gres[1], dp == 2'd2, dp != 2'd0, !av};
      chk(rq, "response", {28'd0, rsp_grant, rsp_reject, rsp_err, rsp_rd_status}, {28'd0, gres});
      chk(rq, "depth", {30'd0, susp_depth}, {30'd0, dp});
      chk(rq, "active", {28'd0, active_valid, av ? active_part : 3'd0}, {28'd0, av, av ? ap : 3'd0});
      chk(rq, "busy", {24'd0, part_busy}, {24'd0, eb});
      chk(rq, "status", {24'd0, status}, {24'd0, es});
   endtask

   task automatic step(logic dn, logic vl, logic [2:0] op, logic [AW-1:0] ad);
      op_done   = dn;
      req_valid = vl;
      req_op    = op;
      req_addr  = ad;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b1;
      req_op    = 3'd2;
      req_addr  = '0;
      op_done   = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state while a request is held on the inputs
      expect_all(1, 4'h0, 2'd0, 1'b0, 3'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NROW; i++) begin
         step(TBL[i].dn, TBL[i].vl, TBL[i].op, TBL[i].ad);
         expect_all(int'(TBL[i].rq), TBL[i].gres, TBL[i].dp, TBL[i].av, TBL[i].ap);
      end

      // R1 reset during a held erase clears it
      step(1'b0, 1'b1, 3'd2, 21'h0C0000);
      step(1'b0, 1'b1, 3'd3, 21'h000000);
      expect_all(6, 4'h8, 2'd1, 1'b0, 3'd0);
      rst_n = 1'b0;
      step(1'b0, 1'b0, 3'd0, 21'h000000);
      step(1'b0, 1'b0, 3'd0, 21'h000000);
      rst_n = 1'b1;
      expect_all(1, 4'h0, 2'd0, 1'b0, 3'd0);
      step(1'b0, 1'b1, 3'd0, 21'h0C0000);
      expect_all(1, 4'h8, 2'd0, 1'b0, 3'd0);
      step(1'b0, 1'b1, 3'd1, 21'h0C0000);
      expect_all(1, 4'h8, 2'd0, 1'b1, 3'd3);

      req_valid = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule